// File: doc/BRIEF.md
# In-Place Radix-2 FFT Engine (256 points)

This block computes a 256-point complex discrete Fourier transform with one radix-2 decimation-in-time butterfly. The butterfly works in place on a two-port working memory and takes its coefficients from a twiddle table. A counter-driven sequencer steps the butterfly through the 8 stages. Use of the block falls into three phases that never overlap. First the caller writes 256 complex samples through the write port, in any order, one per clock. Then the caller pulses `start` and waits while `busy` is high. Finally the caller reads the 256 spectrum bins back through a combinational read port. The engine does no I/O while it computes.

The write port takes the natural sample index. The block stores each sample at the bit-reversed location, so bin k of the result sits at read address k. Every butterfly output is halved, which keeps the data from growing over the 8 stages. The result is the true transform divided by 256, with floor rounding in each stage.

Top module: `fft256_core`

## Requirements
- R1: While `busy` is low, a write with `wrEn` high stores complex sample `wrAddr`. After a transform, read address k returns frequency bin k in natural order.
- R2: A write presented while `busy` is high changes neither the memory nor the transform result.
- R3: A `start` pulse while `busy` is low sets `busy` high and clears `done` on the next clock edge.
- R4: `busy` stays high for exactly 2048 clock cycles per transform (8 stages of 128 butterflies).
- R5: A `start` pulse while `busy` is high is ignored. It does not change the run length or the result.
- R6: `done` rises at the edge where `busy` falls, which is the cycle right after the final write of the last stage. It then stays high through idle cycles, loads and reads until the next accepted `start`.
- R7: A butterfly on a (top) and b (bottom) with twiddle W computes t = b·W, with each part of the product arithmetically shifted right by 15. It writes (a+t)>>>1 to the top location and (a−t)>>>1 to the bottom location, using floor rounding. W for index k has real part round(32767·cos(2πk/256)) and imaginary part round(−32767·sin(2πk/256)), where round(x) = floor(x+0.5).
- R8: `rdRe`/`rdIm` follow `rdAddr` combinationally, with no clock edge needed.
- R9: After reset, `busy` and `done` are low and every memory word reads as zero.
- R10: Each butterfly takes two cycles: an operand-read cycle, then a write-back cycle to the same two addresses. In stage s (0..7), butterfly j uses span h=2^s. Its top address is (j>>s)·2h + (j mod h), its bottom address is top+h, and its twiddle index is (j mod h)·2^(7−s).
- R11: With input parts within ±16383, no butterfly sum leaves the range that fits 16 bits after the halving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Sample write strobe (idle only) |
| wrAddr | input | 8 | Natural sample index |
| wrRe | input | 16 | Sample real part, two's complement |
| wrIm | input | 16 | Sample imaginary part, two's complement |
| start | input | 1 | Begin a transform |
| rdAddr | input | 8 | Result bin index |
| rdRe | output | 16 | Bin real part, combinational |
| rdIm | output | 16 | Bin imaginary part, combinational |
| busy | output | 1 | Transform in progress |
| done | output | 1 | A finished result is held in memory |

## Verification
The embedded properties guard the sequencing on every clock. They check that a write-back always follows an operand read, that busy falls only from the last count, that an accepted start launches the count from zero, that a start while busy leaves the count running, that done holds until a start, that a blocked write leaves its memory word untouched, and that no butterfly sum outgrows the halved 16-bit range. Only the bench scenarios can show that the numbers are right. The bench compares full spectra of an impulse, a tone and bounded random vectors with an independent fixed-point model. It also shows that pokes made mid-run leave the spectrum unchanged, and that the run length and done timing match when counted at the ports.

// File: rtl/fft_pkg.sv
package fft_pkg;
  localparam int LOG2N = 8;
  localparam int NPTS  = 1 << LOG2N;
  localparam int NTW   = NPTS / 2;

  typedef logic [LOG2N-1:0] addr_t;
  typedef logic [LOG2N-2:0] twIdx_t;

  // Strobes and addresses the sequencer hands to the datapath
  typedef struct packed {
    logic   rdOp;     // latch operand pair and twiddle
    logic   wrOp;     // write butterfly results back
    addr_t  topAddr;
    addr_t  botAddr;
    twIdx_t twIdx;
  } bflyCtl_t;
endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
  parameter int TW = 16
) (
  input  fft_pkg::twIdx_t       idx,
  output logic signed [TW-1:0]  wRe,
  output logic signed [TW-1:0]  wIm
);
  import fft_pkg::*;

  // round-half-up of amp*cos (isSin=0) or -amp*sin (isSin=1) of 2*pi*k/NPTS
  function automatic logic signed [TW-1:0] twVal(input int k, input bit isSin);
    real amp, ang, v;
    amp = real'((1 << (TW-1)) - 1);
    ang = 6.283185307179586 * real'(k) / real'(NPTS);
    v   = isSin ? (-amp * $sin(ang)) : (amp * $cos(ang));
    return TW'($rtoi($floor(v + 0.5)));
  endfunction

  logic signed [TW-1:0] romRe [NTW];
  logic signed [TW-1:0] romIm [NTW];

  for (genvar k = 0; k < NTW; k++) begin : g_tw
    assign romRe[k] = twVal(k, 1'b0);
    assign romIm[k] = twVal(k, 1'b1);
  end

  assign wRe = romRe[idx];
  assign wIm = romIm[idx];
endmodule

// File: rtl/fft_ctrl.sv
module fft_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output fft_pkg::bflyCtl_t ctl
);
  import fft_pkg::*;

  localparam int TOTAL = NPTS * LOG2N;
  localparam int CW    = $clog2(TOTAL);
  localparam int SW    = CW - LOG2N;
  localparam logic [CW-1:0] LAST_CNT = CW'(TOTAL - 1);

  logic [CW-1:0] cnt;
  logic          busyQ, doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (!busyQ) begin
      if (start) begin
        busyQ <= 1'b1;
        doneQ <= 1'b0;
        cnt   <= '0;
      end
    end else if (cnt == LAST_CNT) begin
      busyQ <= 1'b0;
      doneQ <= 1'b1;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // count layout: [0] phase, [LOG2N-1:1] butterfly, [CW-1:LOG2N] stage
  logic [SW-1:0]    stg;
  logic [LOG2N-1:0] jIdx, span, posIdx, grpIdx, topA;

  always_comb begin
    stg    = cnt[CW-1:LOG2N];
    jIdx   = LOG2N'(cnt[LOG2N-1:1]);
    span   = LOG2N'(1) << stg;
    posIdx = jIdx & (span - 1'b1);
    grpIdx = jIdx >> stg;
    topA   = LOG2N'(grpIdx << (int'(stg) + 1)) | posIdx;

    ctl.rdOp    = busyQ & ~cnt[0];
    ctl.wrOp    = busyQ &  cnt[0];
    ctl.topAddr = topA;
    ctl.botAddr = topA | span;
    ctl.twIdx   = (LOG2N-1)'(posIdx << (LOG2N - 1 - int'(stg)));
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R10: every write-back cycle is preceded by its operand-read cycle
  a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrOp |-> $past(ctl.rdOp));
  // R10: a read cycle is always followed by its write-back
  a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdOp |=> ctl.wrOp);
  // R3: an accepted start launches the run from count zero
  a_r3_start_launch: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busyQ) |=> (busyQ && !doneQ && cnt == '0));
  // R4: busy ends only after the final count
  a_r4_busy_span: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> ($past(cnt) == LAST_CNT));
  // R5: start while running neither restarts nor stalls the count
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && cnt != LAST_CNT) |=> (busyQ && cnt == $past(cnt) + 1'b1));
  // R6: done holds until the next start
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !start) |=> doneQ);
  // R6: done rises together with the end of the run
  a_r6_done_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $fell(busyQ));
endmodule

// File: rtl/fft_dp.sv
module fft_dp #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busy,
  input  fft_pkg::bflyCtl_t    ctl,
  input  logic                 wrEn,
  input  fft_pkg::addr_t       wrAddr,
  input  logic signed [DW-1:0] wrRe,
  input  logic signed [DW-1:0] wrIm,
  input  fft_pkg::addr_t       rdAddr,
  output logic signed [DW-1:0] rdRe,
  output logic signed [DW-1:0] rdIm
);
  import fft_pkg::*;

  localparam int XW = DW + TW + 1;   // cross-product sum width
  localparam int TPW = DW + 2;       // scaled product width
  localparam int SMW = DW + 3;       // butterfly sum width
  localparam logic signed [SMW-1:0] SUM_MAX = SMW'((1 << DW) - 1);
  localparam logic signed [SMW-1:0] SUM_MIN = -SMW'(1 << DW);

  logic signed [DW-1:0] memRe [NPTS];
  logic signed [DW-1:0] memIm [NPTS];

  // Bit-reversed placement makes the in-place DIT output natural-ordered
  addr_t wrAddrRev;
  for (genvar b = 0; b < LOG2N; b++) begin : g_rev
    assign wrAddrRev[b] = wrAddr[LOG2N-1-b];
  end

  logic signed [TW-1:0] romRe, romIm;
  fft_twiddle_rom #(.TW(TW)) u_rom (
    .idx (ctl.twIdx),
    .wRe (romRe),
    .wIm (romIm)
  );

  // Operand registers filled in the read cycle
  logic signed [DW-1:0] aRe, aIm, bRe, bIm;
  logic signed [TW-1:0] wRe, wIm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aRe <= '0; aIm <= '0; bRe <= '0; bIm <= '0;
      wRe <= '0; wIm <= '0;
    end else if (ctl.rdOp) begin
      aRe <= memRe[ctl.topAddr];
      aIm <= memIm[ctl.topAddr];
      bRe <= memRe[ctl.botAddr];
      bIm <= memIm[ctl.botAddr];
      wRe <= romRe;
      wIm <= romIm;
    end
  end

  // Butterfly: t = b*W, outputs (a +/- t) halved
  logic signed [XW-1:0]  crossRe, crossIm;
  logic signed [TPW-1:0] tRe, tIm;
  logic signed [SMW-1:0] sumRe, sumIm, difRe, difIm;
  logic signed [DW-1:0]  outTopRe, outTopIm, outBotRe, outBotIm;

  always_comb begin
    crossRe = XW'(bRe) * XW'(wRe) - XW'(bIm) * XW'(wIm);
    crossIm = XW'(bRe) * XW'(wIm) + XW'(bIm) * XW'(wRe);
    tRe     = TPW'(crossRe >>> (TW - 1));
    tIm     = TPW'(crossIm >>> (TW - 1));
    sumRe   = SMW'(aRe) + SMW'(tRe);
    sumIm   = SMW'(aIm) + SMW'(tIm);
    difRe   = SMW'(aRe) - SMW'(tRe);
    difIm   = SMW'(aIm) - SMW'(tIm);
    outTopRe = DW'(sumRe >>> 1);
    outTopIm = DW'(sumIm >>> 1);
    outBotRe = DW'(difRe >>> 1);
    outBotIm = DW'(difIm >>> 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPTS; i++) begin
        memRe[i] <= '0;
        memIm[i] <= '0;
      end
    end else if (ctl.wrOp) begin
      memRe[ctl.topAddr] <= outTopRe;
      memIm[ctl.topAddr] <= outTopIm;
      memRe[ctl.botAddr] <= outBotRe;
      memIm[ctl.botAddr] <= outBotIm;
    end else if (wrEn && !busy) begin
      memRe[wrAddrRev] <= wrRe;
      memIm[wrAddrRev] <= wrIm;
    end
  end

  assign rdRe = memRe[rdAddr];
  assign rdIm = memIm[rdAddr];

  // R11: halved butterfly sums fit the data width
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrOp |-> (sumRe <= SUM_MAX && sumRe >= SUM_MIN &&
                  sumIm <= SUM_MAX && sumIm >= SUM_MIN &&
                  difRe <= SUM_MAX && difRe >= SUM_MIN &&
                  difIm <= SUM_MAX && difIm >= SUM_MIN));
  // R2: a load attempt during a run leaves its target word unchanged
  a_r2_load_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && !ctl.wrOp) |=>
      (memRe[$past(wrAddrRev)] == $past(memRe[wrAddrRev]) &&
       memIm[$past(wrAddrRev)] == $past(memIm[wrAddrRev])));
  // R10: the two butterfly locations are distinct
  a_r10_distinct_pair: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrOp |-> (ctl.topAddr != ctl.botAddr));
endmodule

// File: rtl/fft256_core.sv
module fft256_core #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [7:0]           wrAddr,
  input  logic signed [DW-1:0] wrRe,
  input  logic signed [DW-1:0] wrIm,
  input  logic                 start,
  input  logic [7:0]           rdAddr,
  output logic signed [DW-1:0] rdRe,
  output logic signed [DW-1:0] rdIm,
  output logic                 busy,
  output logic                 done
);
  import fft_pkg::*;

  bflyCtl_t ctl;

  fft_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ctl   (ctl)
  );

  fft_dp #(.DW(DW), .TW(TW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .busy   (busy),
    .ctl    (ctl),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrRe   (wrRe),
    .wrIm   (wrIm),
    .rdAddr (rdAddr),
    .rdRe   (rdRe),
    .rdIm   (rdIm)
  );
endmodule

// File: tb/fft256_core_tb.sv
module fft256_core_tb;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [7:0]        wrAddr = '0;
  logic signed [15:0] wrRe = '0, wrIm = '0;
  logic              start = 1'b0;
  logic [7:0]        rdAddr = '0;
  logic signed [15:0] rdRe, rdIm;
  logic              busy, done;

  int nChecks = 0;
  int nErrors = 0;

  int inRe [256];
  int inIm [256];
  int expRe [256];
  int expIm [256];
  int twR [128];
  int twI [128];

  always #10 clk = ~clk;

  fft256_core u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrRe(wrRe),
    .wrIm(wrIm), .start(start), .rdAddr(rdAddr), .rdRe(rdRe), .rdIm(rdIm),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int expv);
    nChecks++;
    if (act !== expv) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int rev8(input int n);
    int r = 0;
    for (int b = 0; b < 8; b++) if (n[b]) r |= 1 << (7 - b);
    return r;
  endfunction

  // Fixed-point reference built from R7 and R10
  task automatic buildModel();
    longint ar, ai, br, bi, tr, ti;
    for (int n = 0; n < 256; n++) begin
      expRe[rev8(n)] = inRe[n];
      expIm[rev8(n)] = inIm[n];
    end
    for (int s = 0; s < 8; s++) begin
      for (int j = 0; j < 128; j++) begin
        int h, pos, top, bot, k;
        h = 1 << s;
        pos = j & (h - 1);
        top = (j >> s) * 2 * h + pos;
        bot = top + h;
        k = pos << (7 - s);
        ar = expRe[top]; ai = expIm[top];
        br = expRe[bot]; bi = expIm[bot];
        tr = (br * twR[k] - bi * twI[k]) >>> 15;
        ti = (br * twI[k] + bi * twR[k]) >>> 15;
        expRe[top] = int'((ar + tr) >>> 1);
        expIm[top] = int'((ai + ti) >>> 1);
        expRe[bot] = int'((ar - tr) >>> 1);
        expIm[bot] = int'((ai - ti) >>> 1);
      end
    end
  endtask

  task automatic loadAll();
    for (int n = 0; n < 256; n++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 8'(n);
      wrRe = 16'(inRe[n]); wrIm = 16'(inIm[n]);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Start a run, count busy cycles at negedges; optional mid-run pokes
  task automatic runFft(input bit poke, output int busyCycles);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", int'(busy), 1);
    chk("R3 done cleared by start", int'(done), 0);
    busyCycles = 0;
    while (busy && busyCycles < 5000) begin
      busyCycles++;
      start = 1'b0; wrEn = 1'b0;
      if (poke && busyCycles == 100) start = 1'b1;            // R5 poke
      if (poke && (busyCycles == 300 || busyCycles == 2047)) begin // R2 poke
        wrEn = 1'b1; wrAddr = 8'(busyCycles & 255);
        wrRe = 16'sh1234; wrIm = -16'sh0777;
      end
      @(negedge clk);
    end
    start = 1'b0; wrEn = 1'b0;
  endtask

  task automatic readCompare(input string req);
    for (int k = 0; k < 256; k++) begin
      rdAddr = 8'(k);
      #1;  // R8: no clock edge between address and data
      chk(req, int'(rdRe), expRe[k]);
      chk(req, int'(rdIm), expIm[k]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin : main
    int cyc;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 128; k++) begin
      real ang;
      ang = 6.283185307179586 * real'(k) / 256.0;
      twR[k] = $rtoi($floor(32767.0 * $cos(ang) + 0.5));
      twI[k] = $rtoi($floor(-32767.0 * $sin(ang) + 0.5));
    end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 done after reset", int'(done), 0);
    rdAddr = 8'd77; #1;
    chk("R9 memory cleared", int'(rdRe), 0);

    // Impulse: every bin equals 16384/256 = 64
    for (int n = 0; n < 256; n++) begin inRe[n] = 0; inIm[n] = 0; end
    inRe[0] = 16384;
    loadAll();
    runFft(1'b0, cyc);
    chk("R4 run length impulse", cyc, 2048);
    chk("R6 done at end", int'(done), 1);
    for (int k = 0; k < 256; k++) begin
      expRe[k] = 64; expIm[k] = 0;
    end
    readCompare("R1 R7 impulse spectrum");

    // R6: done persists through idle cycles and a new load
    repeat (20) @(negedge clk);
    chk("R6 done holds idle", int'(done), 1);

    // Bounded random with pokes during the run
    for (int n = 0; n < 256; n++) begin
      inRe[n] = int'($urandom_range(32766)) - 16383;
      inIm[n] = int'($urandom_range(32766)) - 16383;
    end
    inRe[1] = 16383; inIm[1] = -16383;   // corner: extreme parts
    inRe[2] = -16383; inIm[2] = 16383;
    loadAll();
    chk("R6 done holds through load", int'(done), 1);
    buildModel();
    runFft(1'b1, cyc);
    chk("R5 run length with start poke", cyc, 2048);
    readCompare("R2 R5 R7 R10 R11 random spectrum");

    // Tone at bin 5
    for (int n = 0; n < 256; n++) begin
      inRe[n] = $rtoi($floor(8000.0 * $cos(6.283185307179586 * 5.0 * real'(n) / 256.0) + 0.5));
      inIm[n] = 0;
    end
    loadAll();
    buildModel();
    runFft(1'b0, cyc);
    chk("R4 run length tone", cyc, 2048);
    readCompare("R1 R7 R10 tone spectrum");

    // R8: switching address alone changes the data
    rdAddr = 8'd5; #1;
    chk("R8 async read bin 5", int'(rdRe), expRe[5]);
    rdAddr = 8'd251; #1;
    chk("R8 async read bin 251", int'(rdRe), expRe[251]);

    // Second random run, negative-heavy, no pokes
    for (int n = 0; n < 256; n++) begin
      inRe[n] = -int'($urandom_range(16383));
      inIm[n] = int'($urandom_range(16383)) - 8000;
    end
    loadAll();
    buildModel();
    runFft(1'b0, cyc);
    chk("R4 run length random 2", cyc, 2048);
    readCompare("R7 R10 R11 random spectrum 2");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule